// File: doc/BRIEF.md
# Driver Compensation Code Selector and Calibration Scheduler

This block holds the drive-strength codes for a parallel bus driver. It has two channels, one for the data and command lines and one for the strobes. Each channel carries a pull-up (P) code and a pull-down (N) code. A free-running measurement engine delivers a fresh pair of results for both channels, roughly every four microseconds, with a one-cycle `meas_valid` pulse. The block keeps the latest result of each channel. Per channel it then selects one of three codes: the measured code, a fixed bypass code, or the measured code plus a signed offset, clamped to the code range.

The selected codes reach the driver only at defined points. The first measurement after reset seeds the drive outputs and the impedance code, and the impedance code then stays frozen until the next reset. After seeding, the drive outputs move only inside a calibration cycle. A scheduler counts idle cycles up to a programmable period and then raises a bus request. It waits for the grant and commits the selected codes in a single update cycle. It then drops the request for one release cycle and restarts its period count.

Top module: `drv_comp_sched`

## Requirements
- R1: While reset is asserted and after it is released, `bus_req` is 0 and `drv_dat`, `drv_stb` and `imp_code` are all zero until the first measurement.
- R2: The first cycle with `meas_valid` high after reset loads `imp_code` from `meas_dat` at the next edge. At that same edge, both drive outputs take the codes selected from that result. Later measurements never change `imp_code` until the next reset.
- R3: Each channel has a 2-bit source select. Value 1 selects the bypass code, and values 0 and 3 select the measured code. A channel's select applies to both its P half and its N half. Every packed code bus is {P, N}, with P in the upper CODE_W bits.
- R4: Source value 2 adds the offset, read as a CODE_W-bit two's-complement number, to the measured code. The sum saturates at 0 and at 2^CODE_W-1 and does not wrap.
- R5: After seeding, the drive outputs change only at the edge that ends the update cycle. New measurements, configuration changes or grants at any other time leave them unchanged.
- R6: While `cal_en` is high and seeding is done, `bus_req` rises after `cal_period` consecutive idle cycles. The count restarts from zero each time the scheduler returns to idle.
- R7: No request is raised before seeding or while `cal_en` is low. In both cases the idle count is held at zero.
- R8: `bus_req` stays high until `bus_gnt` is sampled high. The next cycle is the update cycle, with `bus_req` still high. The cycle after that is the release cycle, with `bus_req` low and the new codes on the drive outputs.
- R9: Expiry of the period while a request is pending does not queue a second request. After the release, the next request follows exactly `cal_period` idle cycles later, however long the grant took.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | One-cycle pulse: new measurement on `meas_dat`/`meas_stb` |
| meas_dat | input | 2*CODE_W | Measured data-channel codes {P, N} |
| meas_stb | input | 2*CODE_W | Measured strobe-channel codes {P, N} |
| cfg_dat_src | input | 2 | Data-channel source select |
| cfg_stb_src | input | 2 | Strobe-channel source select |
| cfg_dat_byp | input | 2*CODE_W | Data-channel bypass codes {P, N} |
| cfg_stb_byp | input | 2*CODE_W | Strobe-channel bypass codes {P, N} |
| cfg_dat_off | input | 2*CODE_W | Data-channel signed offsets {P, N} |
| cfg_stb_off | input | 2*CODE_W | Strobe-channel signed offsets {P, N} |
| cal_en | input | 1 | Enables periodic calibration |
| cal_period | input | PER_W | Idle cycles between calibrations |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_req | output | 1 | Bus ownership request |
| drv_dat | output | 2*CODE_W | Data-channel codes applied to the driver {P, N} |
| drv_stb | output | 2*CODE_W | Strobe-channel codes applied to the driver {P, N} |
| imp_code | output | 2*CODE_W | Impedance code frozen from the first measurement |

## Verification
A new measurement or a configuration change can arrive in the same stretch of cycles as a pending bus request. The bench provokes this on purpose: it sends a second measurement while the grant is withheld. It then judges three things. The drive outputs must hold their old value until the release cycle. The impedance code must stay frozen. The value committed at the update must be the one selected from the latest measurement. A second overlap is period expiry during a long-pending request. The bench checks it by counting the idle cycles between the release and the next request.

// File: rtl/drv_comp_pkg.sv
package drv_comp_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_REQ  = 2'd1,
        CAL_UPD  = 2'd2,
        CAL_REL  = 2'd3
    } cal_st_e;

    typedef enum logic [1:0] {
        SRC_CALC  = 2'd0,
        SRC_BYP   = 2'd1,
        SRC_OFF   = 2'd2,
        SRC_CALC2 = 2'd3
    } code_src_e;

    // lanes: data N, data P, strobe N, strobe P
    localparam int LANES = 4;

endpackage

// File: rtl/comp_code_sel.sv
module comp_code_sel
    import drv_comp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] byp_i,
    input  logic [CODE_W-1:0] off_i,
    input  logic [1:0]        src_i,
    output logic [CODE_W-1:0] code_o
);

    localparam int SUM_W = CODE_W + 2;
    localparam logic signed [SUM_W-1:0] CODE_MAX = {2'b00, {CODE_W{1'b1}}};

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, calc_i}) + $signed({{2{off_i[CODE_W-1]}}, off_i});
        case (code_src_e'(src_i))
            SRC_BYP: code_o = byp_i;
            SRC_OFF: begin
                if (sum < 0)
                    code_o = '0;
                else if (sum > CODE_MAX)
                    code_o = '1;
                else
                    code_o = sum[CODE_W-1:0];
            end
            default: code_o = calc_i;
        endcase
    end

endmodule

// File: rtl/cal_sched.sv
module cal_sched
    import drv_comp_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             gnt_i,
    output logic             req_o,
    output logic             upd_o,
    output cal_st_e          st_o
);

    typedef struct packed {
        cal_st_e          st;
        logic [PER_W-1:0] cnt;
    } sched_t;

    sched_t s_d, s_q;
    logic [PER_W:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        cnt_next = {1'b0, s_q.cnt} + (PER_W+1)'(1);
        case (s_q.st)
            CAL_IDLE: begin
                if (!en_i) begin
                    s_d.cnt = '0;
                end else if (cnt_next >= {1'b0, period_i}) begin
                    s_d.st  = CAL_REQ;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = cnt_next[PER_W-1:0];
                end
            end
            CAL_REQ: begin
                if (gnt_i)
                    s_d.st = CAL_UPD;
            end
            CAL_UPD: s_d.st = CAL_REL;
            default: begin
                s_d.st  = CAL_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{st: CAL_IDLE, cnt: '0};
        else
            s_q <= s_d;
    end

    assign req_o = (s_q.st == CAL_REQ) || (s_q.st == CAL_UPD);
    assign upd_o = (s_q.st == CAL_UPD);
    assign st_o  = s_q.st;

endmodule

// File: rtl/drv_comp_sched.sv
module drv_comp_sched
    import drv_comp_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int PER_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_valid,
    input  logic [2*CODE_W-1:0] meas_dat,
    input  logic [2*CODE_W-1:0] meas_stb,
    input  logic [1:0]          cfg_dat_src,
    input  logic [1:0]          cfg_stb_src,
    input  logic [2*CODE_W-1:0] cfg_dat_byp,
    input  logic [2*CODE_W-1:0] cfg_stb_byp,
    input  logic [2*CODE_W-1:0] cfg_dat_off,
    input  logic [2*CODE_W-1:0] cfg_stb_off,
    input  logic                cal_en,
    input  logic [PER_W-1:0]    cal_period,
    input  logic                bus_gnt,
    output logic                bus_req,
    output logic [2*CODE_W-1:0] drv_dat,
    output logic [2*CODE_W-1:0] drv_stb,
    output logic [2*CODE_W-1:0] imp_code
);

    localparam int ALL_W = LANES * CODE_W;
    localparam int CH_W  = 2 * CODE_W;

    typedef struct packed {
        logic [ALL_W-1:0] calc;
        logic [ALL_W-1:0] drv;
        logic [CH_W-1:0]  imp;
        logic             seeded;
    } comp_t;

    comp_t r_d, r_q;

    logic             seed_now;
    logic             upd;
    logic [ALL_W-1:0] calc_in;
    logic [ALL_W-1:0] byp_all;
    logic [ALL_W-1:0] off_all;
    logic [ALL_W-1:0] sel_all;
    cal_st_e          sched_st;
    logic             seeded_w;

    assign seed_now = meas_valid && !r_q.seeded;
    assign calc_in  = seed_now ? {meas_stb, meas_dat} : r_q.calc;
    assign byp_all  = {cfg_stb_byp, cfg_dat_byp};
    assign off_all  = {cfg_stb_off, cfg_dat_off};
    assign seeded_w = r_q.seeded;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0] lane_src;
        assign lane_src = (i < 2) ? cfg_dat_src : cfg_stb_src;
        comp_code_sel #(.CODE_W(CODE_W)) u_sel (
            .calc_i (calc_in[i*CODE_W +: CODE_W]),
            .byp_i  (byp_all[i*CODE_W +: CODE_W]),
            .off_i  (off_all[i*CODE_W +: CODE_W]),
            .src_i  (lane_src),
            .code_o (sel_all[i*CODE_W +: CODE_W])
        );
    end

    cal_sched #(.PER_W(PER_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cal_en && r_q.seeded),
        .period_i (cal_period),
        .gnt_i    (bus_gnt),
        .req_o    (bus_req),
        .upd_o    (upd),
        .st_o     (sched_st)
    );

    always_comb begin
        r_d = r_q;
        if (meas_valid)
            r_d.calc = {meas_stb, meas_dat};
        if (seed_now) begin
            r_d.imp    = meas_dat;
            r_d.seeded = 1'b1;
            r_d.drv    = sel_all;
        end else if (upd) begin
            r_d.drv = sel_all;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign drv_dat  = r_q.drv[CH_W-1:0];
    assign drv_stb  = r_q.drv[ALL_W-1:CH_W];
    assign imp_code = r_q.imp;

endmodule

// File: rtl/drv_comp_chk.sv
module drv_comp_chk
    import drv_comp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_gnt,
    input logic [2*CODE_W-1:0] drv_dat,
    input logic [2*CODE_W-1:0] drv_stb,
    input logic [2*CODE_W-1:0] imp_code,
    input cal_st_e             st,
    input logic                seeded
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAL_REQ && !bus_gnt) |=> (bus_req && st == CAL_REQ)); // R8

    AST_UPD_THEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAL_UPD) |=> !bus_req); // R8

    AST_NO_REQ_UNSEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        !seeded |-> !bus_req); // R7

    AST_IMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> $stable(imp_code)); // R2

    AST_DRV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seeded && st != CAL_UPD) |=> ($stable(drv_dat) && $stable(drv_stb))); // R5

endmodule

bind drv_comp_sched drv_comp_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .drv_dat  (drv_dat),
    .drv_stb  (drv_stb),
    .imp_code (imp_code),
    .st       (sched_st),
    .seeded   (seeded_w)
);

// File: tb/drv_comp_sched_tb.sv
module drv_comp_sched_tb;

    localparam int W  = 4;
    localparam int PW = 8;
    localparam int P  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          meas_valid = 1'b0;
    logic [2*W-1:0] meas_dat = '0, meas_stb = '0;
    logic [1:0]    cfg_dat_src = '0, cfg_stb_src = '0;
    logic [2*W-1:0] cfg_dat_byp = '0, cfg_stb_byp = '0;
    logic [2*W-1:0] cfg_dat_off = '0, cfg_stb_off = '0;
    logic          cal_en = 1'b0;
    logic [PW-1:0] cal_period = PW'(P);
    logic          bus_gnt = 1'b0;
    logic          bus_req;
    logic [2*W-1:0] drv_dat, drv_stb, imp_code;

    int ntot = 0;
    int nbad = 0;
    bit done = 1'b0;
    int prev_dat = 0;
    int prev_stb = 0;

    always #10 clk = ~clk;

    drv_comp_sched #(.CODE_W(W), .PER_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_dat(meas_dat), .meas_stb(meas_stb),
        .cfg_dat_src(cfg_dat_src), .cfg_stb_src(cfg_stb_src),
        .cfg_dat_byp(cfg_dat_byp), .cfg_stb_byp(cfg_stb_byp),
        .cfg_dat_off(cfg_dat_off), .cfg_stb_off(cfg_stb_off),
        .cal_en(cal_en), .cal_period(cal_period), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .drv_dat(drv_dat), .drv_stb(drv_stb),
        .imp_code(imp_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        ntot++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pk(input int p, input int n);
        return (p % 16) * 16 + (n % 16);
    endfunction

    function automatic int code_exp(input int calc, input int byp, input int off, input int src);
        int so;
        int s;
        so = (off >= 8) ? off - 16 : off;
        s  = calc + so;
        case (src)
            1: return byp;
            2: begin
                if (s < 0) return 0;
                if (s > 15) return 15;
                return s;
            end
            default: return calc;
        endcase
    endfunction

    // waits for a request, grants it, checks handshake and committed codes
    task automatic cal_now(input string tag, input int exp_dat, input int exp_stb);
        while (bus_req !== 1'b1) @(negedge clk);
        chk("R5 drv_dat held before grant", int'(drv_dat), prev_dat);
        chk("R5 drv_stb held before grant", int'(drv_stb), prev_stb);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R8 req high in update cycle", int'(bus_req), 1);
        @(negedge clk);
        chk("R8 req low in release cycle", int'(bus_req), 0);
        chk({tag, " drv_dat"}, int'(drv_dat), exp_dat);
        chk({tag, " drv_stb"}, int'(drv_stb), exp_stb);
        prev_dat = exp_dat;
        prev_stb = exp_stb;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            ntot++;
            nbad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        int k;
        bit ok;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", int'(bus_req), 0);
        chk("R1 drv in reset", int'({drv_dat, drv_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 imp after reset", int'(imp_code), 0);
        chk("R1 drv after reset", int'({drv_dat, drv_stb}), 0);

        // R7: enabled but not yet seeded
        cal_en = 1'b1;
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (bus_req) ok = 1'b0;
        end
        chk("R7 no request before seeding", int'(ok), 1);

        // R2: seeding with data=measured, strobe=bypass (R3)
        cfg_dat_src = 2'd0;
        cfg_stb_src = 2'd1;
        cfg_stb_byp = 8'(pk(9, 2));
        meas_dat    = 8'(pk(5, 11));
        meas_stb    = 8'(pk(1, 1));
        meas_valid  = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
        chk("R2 imp seeded", int'(imp_code), pk(5, 11));
        chk("R2 drv_dat seeded", int'(drv_dat), pk(5, 11));
        chk("R3 drv_stb bypass at seed", int'(drv_stb), pk(9, 2));
        prev_dat = pk(5, 11);
        prev_stb = pk(9, 2);

        // R6: first request after P idle cycles
        k = 0;
        while (!bus_req && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk("R6 idle cycles to first request", k, P);

        // R8/R5/R2: hold grant off, new measurement arrives meanwhile
        ok = 1'b1;
        for (int j = 0; j < 20; j++) begin
            if (j == 5) begin
                meas_dat   = 8'(pk(12, 3));
                meas_valid = 1'b1;
            end else begin
                meas_valid = 1'b0;
            end
            @(negedge clk);
            if (!bus_req) ok = 1'b0;
        end
        meas_valid = 1'b0;
        chk("R8 request held without grant", int'(ok), 1);
        chk("R2 imp frozen after second result", int'(imp_code), pk(5, 11));
        cal_now("R8 commit latest", pk(12, 3), pk(9, 2));

        // R9: next request exactly P idle cycles after release
        k = 0;
        while (!bus_req && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk("R9 no queued request, period restarts", k, P + 1);
        cal_now("R8 second commit", pk(12, 3), pk(9, 2));

        // R7: disabled
        cal_en = 1'b0;
        ok = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (bus_req) ok = 1'b0;
        end
        chk("R7 no request while disabled", int'(ok), 1);
        chk("R5 drv stable while disabled", int'(drv_dat), prev_dat);
        cal_en = 1'b1;

        // R3/R4 sweep: every mode, measured value and offset
        for (int mode = 0; mode < 4; mode++) begin
            for (int c = 0; c < 16; c++) begin
                for (int o = 0; o < 16; o++) begin
                    int dcp, dcn, dbp, dbn, dop, don;
                    int scp, scn, sbp, sbn, sop, son;
                    int smode, ed, es;
                    dcp = c;            dcn = 15 - c;
                    dbp = o;            dbn = c;
                    dop = o;            don = (16 - o) % 16;
                    scp = (c + o) % 16; scn = o;
                    sbp = 15 - o;       sbn = (c * 3) % 16;
                    sop = (o + 3) % 16; son = o;
                    smode = (mode + 1) % 4;
                    cfg_dat_src = 2'(mode);
                    cfg_stb_src = 2'(smode);
                    meas_dat    = 8'(pk(dcp, dcn));
                    meas_stb    = 8'(pk(scp, scn));
                    cfg_dat_byp = 8'(pk(dbp, dbn));
                    cfg_stb_byp = 8'(pk(sbp, sbn));
                    cfg_dat_off = 8'(pk(dop, don));
                    cfg_stb_off = 8'(pk(sop, son));
                    meas_valid  = 1'b1;
                    @(negedge clk);
                    meas_valid = 1'b0;
                    ed = pk(code_exp(dcp, dbp, dop, mode), code_exp(dcn, dbn, don, mode));
                    es = pk(code_exp(scp, sbp, sop, smode), code_exp(scn, sbn, son, smode));
                    cal_now("R3/R4 sweep", ed, es);
                end
            end
        end

        chk("R2 imp frozen after sweep", int'(imp_code), pk(5, 11));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

endmodule